// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into a 1024-word on-chip RAM that it uses as a ring, so the RAM always holds the most recent activity. A trigger input starts a programmable post-trigger countdown. When the countdown reaches its end, the block stops capturing, and the stored history then spans the moments before and after the event of interest.

Software controls the block through a simple word-addressed register port. It chooses the capture mode, sets the post-trigger word count, starts and stops sessions, and polls status. After a session ends, software empties the buffer oldest-first by reading one register over and over until the all-ones end marker appears. A key register guards every configuration write.

Top module: `trace_ring_capture`

## Requirements
- R1: Register word offsets are 0 mode, 1 control, 2 trigger count, 3 status, 4 read data, 5 lock. Status bits are bit0 ready, bit1 triggered, bit2 wrapped and bit3 locked. A read strobe returns data on reg_rdata_o after the next clock edge. After reset, status reads 0x9 (ready and locked).
- R2: While the block is locked, writes to mode, control and trigger count have no effect. Writing 0xC5ACCE55 to the lock register unlocks the block. Writing any other value to it locks the block again.
- R3: Writing control bit0=1 while idle or stopped starts a session. It resets the write pointer to address 0 and clears the wrapped and triggered flags, so status reads 0x0. Writing control bit0=0 during a session stops capture.
- R4: In ring mode (mode bit0=1, the reset value), each valid word is written at the write pointer, which then advances modulo 1024. Once 1024 words are held, new words overwrite the oldest one and status bit2 (wrapped) is set.
- R5: The first trigger in a session sets status bit1. After that, exactly the trigger-count number of further words are stored, and then capture stops. The word accepted in the trigger cycle is stored but is not counted. A count of 0 stops capture at the end of the trigger cycle.
- R6: A trigger that arrives while a countdown is already running is ignored, and so is a trigger that arrives outside a session.
- R7: In fill-once mode (mode bit0=0), capture stops by itself after 1024 words have been stored, and the wrapped flag stays clear.
- R8: After capture stops, each read of the read-data register returns the stored words oldest-first. Reading starts at address 0 if the ring never wrapped, and at the write pointer if it did. The read-data register returns 0xFFFFFFFF once all stored words have been read, and at any time no stopped session is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trace_valid_i | input | 1 | Trace word is valid this cycle |
| trace_data_i | input | 32 | Trace word |
| trig_i | input | 1 | Trigger event |
| reg_addr_i | input | 3 | Register word offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |

## Verification
The checker assumes that reg_wr_i and reg_rd_i are never asserted in the same cycle. It also assumes that trig_i and trace_valid_i are only meaningful at clock edges and are held steady between them. The bench keeps to these assumptions: every input changes on the falling clock edge, and each register access is a single one-cycle strobe followed by an idle cycle. The bench exercises retriggering only with single-cycle trigger pulses that are well apart, so each trigger arrives at a known count of stored words.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_CTRL = 3'd1,
    A_TRIG = 3'd2,
    A_STAT = 3'd3,
    A_DATA = 3'd4,
    A_LOCK = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPT,
    ST_DONE
  } cap_state_e;

  typedef struct packed {
    logic locked;
    logic wrapped;
    logic triggered;
    logic ready;
  } status_t;

  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
  localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/trace_ring_mem.sv
module trace_ring_mem #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trace_ring_regs.sv
module trace_ring_regs
  import trace_ring_pkg::*;
#(
  parameter int unsigned TCW = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     reg_addr_i,
  input  logic           reg_wr_i,
  input  logic [31:0]    reg_wdata_i,
  input  logic           capturing_i,
  output logic           locked_o,
  output logic           ring_mode_o,
  output logic [TCW-1:0] trig_cnt_o,
  output logic           start_o,
  output logic           halt_o
);
  reg_addr_e addr;
  logic      wr_ok;
  logic      locked_q, ring_q;
  logic [TCW-1:0] trig_q;

  assign addr  = reg_addr_e'(reg_addr_i);
  assign wr_ok = reg_wr_i && !locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      ring_q   <= 1'b1;
      trig_q   <= '0;
    end else begin
      if (reg_wr_i && addr == A_LOCK) locked_q <= (reg_wdata_i != UNLOCK_KEY);
      if (wr_ok && addr == A_MODE)    ring_q   <= reg_wdata_i[0];
      if (wr_ok && addr == A_TRIG)    trig_q   <= reg_wdata_i[TCW-1:0];
    end
  end

  // control writes become one-cycle commands
  assign start_o = wr_ok && addr == A_CTRL && reg_wdata_i[0] && !capturing_i;
  assign halt_o  = wr_ok && addr == A_CTRL && !reg_wdata_i[0] && capturing_i;

  assign locked_o    = locked_q;
  assign ring_mode_o = ring_q;
  assign trig_cnt_o  = trig_q;
endmodule

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl
  import trace_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned TCW  = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           halt_i,
  input  logic           ring_mode_i,
  input  logic [TCW-1:0] trig_cnt_i,
  input  logic           trace_valid_i,
  input  logic           trig_i,
  input  logic           pop_i,
  output logic           capturing_o,
  output logic           triggered_o,
  output logic           wrapped_o,
  output logic           avail_o,
  output logic           we_o,
  output logic [AW-1:0]  waddr_o,
  output logic [AW-1:0]  raddr_o,
  output logic [TCW-1:0] post_left_o,
  output logic [AW:0]    fill_cnt_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT  = (AW + 1)'(DEPTH);

  cap_state_e state_q;
  logic [AW-1:0]  wptr_q, rptr_q, wptr_nx;
  logic [AW:0]    fill_q, rd_left_q, fill_nx;
  logic [TCW-1:0] post_q;
  logic           trig_seen_q, wrapped_q;
  logic           capturing, store, full, trig_hit, stop;

  assign capturing = state_q == ST_CAPT;
  assign store     = capturing && trace_valid_i;
  assign full      = fill_q == FULL_CNT;
  assign trig_hit  = capturing && trig_i && !trig_seen_q;

  always_comb begin
    wptr_nx = wptr_q;
    fill_nx = fill_q;
    if (store) begin
      wptr_nx = (wptr_q == LAST_ADDR) ? '0 : wptr_q + 1'b1;
      if (!full) fill_nx = fill_q + 1'b1;
    end
  end

  assign stop = capturing && (halt_i
              || (trig_hit && trig_cnt_i == '0)
              || (trig_seen_q && store && post_q == TCW'(1))
              || (!ring_mode_i && store && fill_q == FULL_CNT - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wptr_q      <= '0;
      rptr_q      <= '0;
      fill_q      <= '0;
      rd_left_q   <= '0;
      post_q      <= '0;
      trig_seen_q <= 1'b0;
      wrapped_q   <= 1'b0;
    end else if (start_i) begin
      state_q     <= ST_CAPT;
      wptr_q      <= '0;
      rptr_q      <= '0;
      fill_q      <= '0;
      rd_left_q   <= '0;
      post_q      <= '0;
      trig_seen_q <= 1'b0;
      wrapped_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_CAPT: begin
          wptr_q <= wptr_nx;
          fill_q <= fill_nx;
          if (store && full) wrapped_q <= 1'b1;
          if (trig_hit) begin
            trig_seen_q <= 1'b1;
            post_q      <= trig_cnt_i;
          end else if (trig_seen_q && store) begin
            post_q <= post_q - 1'b1;
          end
          if (stop) begin
            state_q   <= ST_DONE;
            // oldest word sits at the write pointer once the ring is full
            rptr_q    <= (fill_nx == FULL_CNT) ? wptr_nx : '0;
            rd_left_q <= fill_nx;
          end
        end
        ST_DONE: begin
          if (pop_i && rd_left_q != '0) begin
            rptr_q    <= (rptr_q == LAST_ADDR) ? '0 : rptr_q + 1'b1;
            rd_left_q <= rd_left_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign capturing_o = capturing;
  assign triggered_o = trig_seen_q;
  assign wrapped_o   = wrapped_q;
  assign avail_o     = state_q == ST_DONE && rd_left_q != '0;
  assign we_o        = store;
  assign waddr_o     = wptr_q;
  assign raddr_o     = rptr_q;
  assign post_left_o = post_q;
  assign fill_cnt_o  = fill_q;
endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
  import trace_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned TCW  = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trace_valid_i,
  input  logic [DW-1:0] trace_data_i,
  input  logic          trig_i,
  input  logic [2:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o
);
  reg_addr_e      addr;
  logic           locked, ring_mode, start_pulse, halt_pulse;
  logic [TCW-1:0] trig_cnt, post_left;
  logic           capturing, triggered, wrapped, avail, mem_we;
  logic [AW-1:0]  waddr, raddr;
  logic [AW:0]    fill_cnt;
  logic [DW-1:0]  mem_rdata;
  logic [31:0]    rdata_q;
  status_t        stat;

  assign addr = reg_addr_e'(reg_addr_i);

  trace_ring_regs #(.TCW(TCW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .capturing_i (capturing),
    .locked_o    (locked),
    .ring_mode_o (ring_mode),
    .trig_cnt_o  (trig_cnt),
    .start_o     (start_pulse),
    .halt_o      (halt_pulse)
  );

  trace_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_pulse),
    .halt_i        (halt_pulse),
    .ring_mode_i   (ring_mode),
    .trig_cnt_i    (trig_cnt),
    .trace_valid_i (trace_valid_i),
    .trig_i        (trig_i),
    .pop_i         (reg_rd_i && addr == A_DATA),
    .capturing_o   (capturing),
    .triggered_o   (triggered),
    .wrapped_o     (wrapped),
    .avail_o       (avail),
    .we_o          (mem_we),
    .waddr_o       (waddr),
    .raddr_o       (raddr),
    .post_left_o   (post_left),
    .fill_cnt_o    (fill_cnt)
  );

  trace_ring_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wdata_i (trace_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  assign stat = '{locked: locked, wrapped: wrapped, triggered: triggered, ready: !capturing};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      case (addr)
        A_MODE:  rdata_q <= {31'd0, ring_mode};
        A_CTRL:  rdata_q <= {31'd0, capturing};
        A_TRIG:  rdata_q <= 32'(trig_cnt);
        A_STAT:  rdata_q <= 32'(stat);
        A_DATA:  rdata_q <= avail ? 32'(mem_rdata) : EMPTY_WORD;
        A_LOCK:  rdata_q <= {31'd0, locked};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/trace_ring_checker.sv
module trace_ring_checker
  import trace_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned TCW  = AW + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           trace_valid_i,
  input logic           trig_i,
  input logic [2:0]     reg_addr_i,
  input logic           reg_wr_i,
  input logic           reg_rd_i,
  input logic [31:0]    reg_rdata_o,
  input logic           locked,
  input logic           ring_mode,
  input logic [TCW-1:0] trig_cnt,
  input logic           start_pulse,
  input logic           capturing,
  input logic           triggered,
  input logic           wrapped,
  input logic [AW-1:0]  waddr,
  input logic [TCW-1:0] post_left,
  input logic [AW:0]    fill_cnt
);
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && !(reg_wr_i && reg_addr_i == A_LOCK) |=> $stable(ring_mode) && $stable(trig_cnt));

  p_start_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse |=> capturing && !wrapped && !triggered && waddr == '0);

  p_wptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capturing && trace_valid_i |=>
      waddr == (($past(waddr) == AW'(DEPTH - 1)) ? '0 : $past(waddr) + 1'b1));

  p_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capturing && !start_pulse |=> $stable(waddr));

  p_retrig_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capturing && triggered && trig_i && !trace_valid_i |=> $stable(post_left));

  p_fill_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt <= (AW + 1)'(DEPTH));

  p_sentinel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i == A_DATA && capturing |=> reg_rdata_o == EMPTY_WORD);
endmodule

bind trace_ring_capture trace_ring_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trace_valid_i (trace_valid_i),
  .trig_i        (trig_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wr_i      (reg_wr_i),
  .reg_rd_i      (reg_rd_i),
  .reg_rdata_o   (reg_rdata_o),
  .locked        (locked),
  .ring_mode     (ring_mode),
  .trig_cnt      (trig_cnt),
  .start_pulse   (start_pulse),
  .capturing     (capturing),
  .triggered     (triggered),
  .wrapped       (wrapped),
  .waddr         (waddr),
  .post_left     (post_left),
  .fill_cnt      (fill_cnt)
);

// File: tb/trace_ring_capture_bench.sv
`timescale 1ns/1ps
module trace_ring_capture_bench;
  import trace_ring_pkg::*;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_valid = 1'b0;
  logic [31:0] trace_data = '0;
  logic        trig = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trace_ring_capture u_trace_ring_capture (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .trace_valid_i (trace_valid),
    .trace_data_i  (trace_data),
    .trig_i        (trig),
    .reg_addr_i    (reg_addr),
    .reg_wr_i      (reg_wr),
    .reg_rd_i      (reg_rd),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(reg_addr_e a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(reg_addr_e a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(int n, logic [31:0] base, int t1, int t2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trace_valid = 1'b1;
      trace_data  = base + 32'(i);
      trig        = (i == t1) || (i == t2);
    end
    @(negedge clk);
    trace_valid = 1'b0;
    trig        = 1'b0;
  endtask

  task automatic drain(string tag, int n, logic [31:0] first);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      rd(A_DATA, v);
      chk(tag, v, first + 32'(i));
    end
    rd(A_DATA, v);
    chk({tag, " sentinel R8"}, v, EMPTY_WORD);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v); chk("R1 reset status", v, 32'h9);
    rd(A_DATA, v); chk("R8 idle read", v, EMPTY_WORD);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R2 locked ctrl ignored", v, 32'h9);
    wr(A_TRIG, 32'h7);
    rd(A_TRIG, v); chk("R2 locked trig ignored", v, 32'h0);
    wr(A_LOCK, UNLOCK_KEY);
    rd(A_STAT, v); chk("R2 unlocked", v, 32'h1);
    wr(A_LOCK, 32'h1234);
    rd(A_STAT, v); chk("R2 relocked", v, 32'h9);
    wr(A_LOCK, UNLOCK_KEY);
  endtask

  task automatic t_idle_trig;
    logic [31:0] v;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    wr(A_TRIG, 32'd2);
    wr(A_CTRL, 32'h1);
    push(4, 32'h40, -1, -1);
    rd(A_STAT, v); chk("R6 idle trigger ignored", v, 32'h0);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, v); chk("R3 software stop", v, 32'h1);
    drain("R3 stop drain", 4, 32'h40);
  endtask

  task automatic t_trig_basic;
    logic [31:0] v;
    wr(A_TRIG, 32'd3);
    wr(A_CTRL, 32'h1);
    push(10, 32'h100, 4, -1);
    rd(A_STAT, v); chk("R5 stopped after count", v, 32'h3);
    drain("R5 post-trigger words", 8, 32'h100);
  endtask

  task automatic t_retrig;
    wr(A_TRIG, 32'd4);
    wr(A_CTRL, 32'h1);
    push(20, 32'h200, 2, 4);
    drain("R6 retrigger ignored", 7, 32'h200);
  endtask

  task automatic t_zero;
    wr(A_TRIG, 32'd0);
    wr(A_CTRL, 32'h1);
    push(6, 32'h300, 2, -1);
    drain("R5 zero count", 3, 32'h300);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(A_TRIG, 32'd5);
    wr(A_CTRL, 32'h1);
    push(DEPTH + 6, 32'h1000, DEPTH - 4, -1);
    rd(A_STAT, v); chk("R4 wrapped status", v, 32'h7);
    drain("R4 R8 ring order", DEPTH, 32'h1002);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R3 re-enable clears wrapped", v, 32'h0);
    rd(A_DATA, v); chk("R8 read while capturing", v, EMPTY_WORD);
    wr(A_CTRL, 32'h0);
    drain("R3 empty session", 0, 32'h0);
  endtask

  task automatic t_fill;
    logic [31:0] v;
    wr(A_MODE, 32'h0);
    wr(A_CTRL, 32'h1);
    push(DEPTH + 6, 32'h5000, -1, -1);
    rd(A_STAT, v); chk("R7 fill-once stopped", v, 32'h1);
    drain("R7 fill-once order", DEPTH, 32'h5000);
    wr(A_MODE, 32'h1);
    rd(A_MODE, v); chk("R4 ring mode restored", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_idle_trig();
    t_trig_basic();
    t_retrig();
    t_zero();
    t_wrap();
    t_fill();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule